// File: doc/BRIEF.md
# Multichannel Serial ADC Scan Sequencer

This block is an SPI master for an eight-input serial converter whose resolution is 8, 10 or 12 bits. A start pulse, together with a channel mask, launches a scan. For each enabled channel, going from the lowest index to the highest, the block sends one 16-bit configuration word in its own chip-select frame. The converter answers a command in the frame that follows it. The block therefore closes every scan with one extra frame that carries an all-zero word, and that frame collects the last result.

Each returned word carries a 4-bit tag naming the channel it was taken from. The block compares this tag with the channel it asked for. A matching result is reduced to a right-aligned sample and stored in the next buffer slot. A mismatch raises a sticky error flag, and the slot is left untouched. A one-bit range input selects between a full-scale span equal to the reference and one twice as large. A single-channel read is simply a mask with one bit set, which takes two frames.

Top module: `adc_scan_seq`

## Requirements
- R1: Each command word is `{ctl[11:0], 4'b0000}`, shifted out MSB first. In `ctl`: bit 11 = 1 (write), bits 9:6 = channel, bits 5:4 = 2'b11 (normal power), bit 10 and bit 3 = 0 (sequencer off), bit 1 = range select, bit 0 = 1 (straight binary). All other bits are 0.
- R2: `sclk` idles high whenever `csN` is high. `mosi` changes only on a falling `sclk`, and `miso` is sampled on a rising `sclk`. Every frame has exactly 16 rising edges.
- R3: The range bit (word bit 5) equals `rangeRef` as sampled with the accepted start, and it keeps that value for the whole scan.
- R4: Result word bits 15:12 are the tag and bits 11:0 the raw field. The stored sample is `raw >> (12 - RES_BITS)`, truncated to RES_BITS bits.
- R5: A scan of M enabled channels runs M+1 frames. Commands go in ascending channel order, and the last frame sends 16'h0000.
- R6: The result of the k-th command (counting from 0 in mask order) goes to slot k, at `bufData[k*RES_BITS +: RES_BITS]`, and sets `slotValid[k]`. Slots at index M and above stay invalid.
- R7: `done` is high for exactly one cycle. For a non-empty scan, that cycle is the one in which `csN` rises at the end of frame M+1.
- R8: A tag that differs from the requested channel sets `ioErr`, leaves that slot's data and valid bit unchanged, and still advances the slot index. `ioErr` stays set until the next accepted start.
- R9: A start with an all-zero mask pulses `done` in the following cycle, produces no chip-select activity, and does not assert `busy`.
- R10: A start while `busy` is high is ignored.
- R11: `csN` stays high for at least 2*SCLK_HALF clock cycles (one SCLK period) between frames.
- R12: A one-bit mask runs exactly two frames: the command frame, then one result frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Scan request, accepted only while idle |
| chanMask | input | NUM_CH | Channels to convert |
| rangeRef | input | 1 | 1 = span equals reference, 0 = twice reference |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle pulse at scan completion |
| ioErr | output | 1 | Sticky tag-mismatch flag |
| slotValid | output | NUM_CH | Per-slot valid bits |
| bufData | output | NUM_CH*RES_BITS | Packed sample slots |
| sclk | output | 1 | Serial clock |
| csN | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial command data |
| miso | input | 1 | Serial result data |

## Verification
The completion pulse must arrive in the same cycle that chip select rises after frame M+1. For an empty mask, it must arrive one cycle after start. The reference model counts chip-select rising edges from the port and checks `done` against that count, sampling 2 ns after every rising clock edge, so any early, late or repeated pulse is caught. Buffer contents, valid bits and the error flag are compared only once `busy` has dropped, because the last slot is written in the completion cycle. Chip-select gaps are measured in sampled cycles.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int FRAME_W = 16;
  localparam int CTL_W   = 12;
  localparam int TAG_W   = 4;

  localparam logic [1:0] PWR_NORMAL = 2'd3;
  localparam logic [1:0] SEQ_NONE   = 2'd0;

  typedef struct packed {
    logic clear;
    logic load;
    logic cmdValid;
    logic fall;
    logic rise;
    logic frameEnd;
  } seqStb_t;

  function automatic logic [CTL_W-1:0] buildCtl(
    input logic [TAG_W-1:0] ch,
    input logic [1:0]       pm,
    input logic [1:0]       seq,
    input logic             rng
  );
    logic [CTL_W-1:0] c;
    c       = '0;
    c[11]   = 1'b1;
    c[10]   = seq[1];
    c[9:6]  = ch;
    c[5:4]  = pm;
    c[3]    = seq[0];
    c[1]    = rng;
    c[0]    = 1'b1;
    return c;
  endfunction
endpackage

// File: rtl/adc_chan_pick.sv
module adc_chan_pick #(
  parameter int NUM_CH = 8,
  parameter int CH_W   = 3
) (
  input  logic [NUM_CH-1:0] maskIn,
  output logic              anySet,
  output logic [CH_W-1:0]   lowChan,
  output logic [NUM_CH-1:0] lowOneHot
);
  logic [NUM_CH:0] below;
  assign below[0] = 1'b0;

  for (genvar g = 0; g < NUM_CH; g++) begin : gLow
    assign lowOneHot[g] = maskIn[g] & ~below[g];
    assign below[g+1]   = below[g] | maskIn[g];
  end

  assign anySet = below[NUM_CH];

  always_comb begin
    lowChan = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (lowOneHot[i]) lowChan = CH_W'(i);
    end
  end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int NUM_CH    = 8,
  parameter int CH_W      = 3,
  parameter int SCLK_HALF = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [NUM_CH-1:0] chanMask,
  input  logic              pickAny,
  input  logic [CH_W-1:0]   pickChan,
  input  logic [NUM_CH-1:0] pickOneHot,
  output logic [NUM_CH-1:0] maskRem,
  output seqStb_t           stb,
  output logic [CH_W-1:0]   cmdChan,
  output logic              sclk,
  output logic              csN,
  output logic              done,
  output logic              busy
);
  localparam int TICK_W = $clog2(2*SCLK_HALF) + 1;
  localparam int BIT_W  = $clog2(FRAME_W + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_GAP, ST_FRAME} state_t;

  state_t           state;
  logic [TICK_W-1:0] tick;
  logic [BIT_W-1:0]  bitCnt;
  logic              tailFrame;
  logic              halfEnd, gapEnd, frameDone;

  assign halfEnd   = (tick == TICK_W'(SCLK_HALF - 1));
  assign gapEnd    = (tick == TICK_W'(2*SCLK_HALF - 1));
  assign frameDone = (bitCnt == BIT_W'(FRAME_W));
  assign cmdChan   = pickChan;
  assign busy      = (state != ST_IDLE);

  always_comb begin
    stb = '0;
    case (state)
      ST_IDLE: stb.clear = start;
      ST_GAP: begin
        if (gapEnd && !tailFrame) begin
          stb.load     = 1'b1;
          stb.cmdValid = pickAny;
        end
      end
      ST_FRAME: begin
        if (halfEnd) begin
          if (frameDone)  stb.frameEnd = 1'b1;
          else if (sclk)  stb.fall     = 1'b1;
          else            stb.rise     = 1'b1;
        end
      end
      default: stb = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      tick      <= '0;
      bitCnt    <= '0;
      sclk      <= 1'b1;
      csN       <= 1'b1;
      done      <= 1'b0;
      tailFrame <= 1'b0;
      maskRem   <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            maskRem   <= chanMask;
            tailFrame <= 1'b0;
            if (chanMask == '0) begin
              done <= 1'b1;
            end else begin
              state <= ST_GAP;
              tick  <= TICK_W'(2*SCLK_HALF - 1);
            end
          end
        end
        ST_GAP: begin
          if (gapEnd) begin
            tick <= '0;
            if (tailFrame) begin
              state     <= ST_IDLE;
              tailFrame <= 1'b0;
            end else begin
              state  <= ST_FRAME;
              csN    <= 1'b0;
              bitCnt <= '0;
              if (pickAny) maskRem   <= maskRem & ~pickOneHot;
              else         tailFrame <= 1'b1;
            end
          end else begin
            tick <= tick + 1'b1;
          end
        end
        ST_FRAME: begin
          if (halfEnd) begin
            tick <= '0;
            if (frameDone) begin
              csN   <= 1'b1;
              state <= ST_GAP;
              done  <= tailFrame;
            end else if (sclk) begin
              sclk <= 1'b0;
            end else begin
              sclk   <= 1'b1;
              bitCnt <= bitCnt + 1'b1;
            end
          end else begin
            tick <= tick + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_seq_dp.sv
module adc_seq_dp
  import adc_seq_pkg::*;
#(
  parameter int NUM_CH   = 8,
  parameter int CH_W     = 3,
  parameter int RES_BITS = 12
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  seqStb_t                    stb,
  input  logic [CH_W-1:0]            cmdChan,
  input  logic                       rangeRef,
  input  logic                       miso,
  output logic                       mosi,
  output logic [NUM_CH*RES_BITS-1:0] bufData,
  output logic [NUM_CH-1:0]          slotValid,
  output logic                       ioErr
);
  localparam int SHIFT  = CTL_W - RES_BITS;
  localparam int SLOT_W = $clog2(NUM_CH + 1);

  logic [FRAME_W-1:0] txShift, rxShift, txWord;
  logic [CTL_W-1:0]   ctlWord;
  logic               rangeLat;
  logic [CH_W-1:0]    curChan, expChan;
  logic               curValid, expValid;
  logic [SLOT_W-1:0]  slotIdx;
  logic               tagOk, wrEn;
  logic [RES_BITS-1:0] sampleVal;

  assign ctlWord   = buildCtl(TAG_W'(cmdChan), PWR_NORMAL, SEQ_NONE, rangeLat);
  assign txWord    = {ctlWord, 4'b0000};
  assign tagOk     = (rxShift[FRAME_W-1 -: TAG_W] == TAG_W'(expChan));
  assign sampleVal = RES_BITS'(rxShift[CTL_W-1:0] >> SHIFT);
  assign wrEn      = stb.frameEnd && expValid && tagOk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift  <= '0;
      rxShift  <= '0;
      mosi     <= 1'b0;
      rangeLat <= 1'b0;
      curChan  <= '0;
      curValid <= 1'b0;
      expChan  <= '0;
      expValid <= 1'b0;
      slotIdx  <= '0;
      ioErr    <= 1'b0;
    end else begin
      if (stb.clear) begin
        rangeLat <= rangeRef;
        curValid <= 1'b0;
        expValid <= 1'b0;
        slotIdx  <= '0;
        ioErr    <= 1'b0;
      end
      if (stb.load) begin
        txShift  <= stb.cmdValid ? txWord : '0;
        curChan  <= cmdChan;
        curValid <= stb.cmdValid;
      end
      if (stb.fall) begin
        mosi    <= txShift[FRAME_W-1];
        txShift <= {txShift[FRAME_W-2:0], 1'b0};
      end
      if (stb.rise) begin
        rxShift <= {rxShift[FRAME_W-2:0], miso};
      end
      if (stb.frameEnd) begin
        expChan  <= curChan;
        expValid <= curValid;
        if (expValid) begin
          slotIdx <= slotIdx + 1'b1;
          if (!tagOk) ioErr <= 1'b1;
        end
      end
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : gSlot
    logic [RES_BITS-1:0] slotQ;
    logic                slotOk;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        slotQ  <= '0;
        slotOk <= 1'b0;
      end else if (stb.clear) begin
        slotOk <= 1'b0;
      end else if (wrEn && slotIdx == SLOT_W'(g)) begin
        slotQ  <= sampleVal;
        slotOk <= 1'b1;
      end
    end
    assign bufData[g*RES_BITS +: RES_BITS] = slotQ;
    assign slotValid[g] = slotOk;
  end
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_seq_pkg::*;
#(
  parameter int NUM_CH    = 8,
  parameter int RES_BITS  = 12,
  parameter int SCLK_HALF = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       start,
  input  logic [NUM_CH-1:0]          chanMask,
  input  logic                       rangeRef,
  output logic                       busy,
  output logic                       done,
  output logic                       ioErr,
  output logic [NUM_CH-1:0]          slotValid,
  output logic [NUM_CH*RES_BITS-1:0] bufData,
  output logic                       sclk,
  output logic                       csN,
  output logic                       mosi,
  input  logic                       miso
);
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic [NUM_CH-1:0] maskRem, pickOneHot;
  logic              pickAny;
  logic [CH_W-1:0]   pickChan, cmdChan;
  seqStb_t           stb;

  adc_chan_pick #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_pick (
    .maskIn(maskRem), .anySet(pickAny), .lowChan(pickChan), .lowOneHot(pickOneHot)
  );

  adc_seq_ctrl #(.NUM_CH(NUM_CH), .CH_W(CH_W), .SCLK_HALF(SCLK_HALF)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .chanMask(chanMask),
    .pickAny(pickAny), .pickChan(pickChan), .pickOneHot(pickOneHot),
    .maskRem(maskRem), .stb(stb), .cmdChan(cmdChan),
    .sclk(sclk), .csN(csN), .done(done), .busy(busy)
  );

  adc_seq_dp #(.NUM_CH(NUM_CH), .CH_W(CH_W), .RES_BITS(RES_BITS)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .cmdChan(cmdChan), .rangeRef(rangeRef),
    .miso(miso), .mosi(mosi), .bufData(bufData), .slotValid(slotValid), .ioErr(ioErr)
  );
endmodule

// File: rtl/adc_scan_seq_chk.sv
module adc_scan_seq_chk #(
  parameter int NUM_CH = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic [NUM_CH-1:0] chanMask,
  input logic              busy,
  input logic              done,
  input logic              ioErr,
  input logic              sclk,
  input logic              csN,
  input logic              mosi
);
  AST_SCLK_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> sclk); // R2

  AST_MOSI_ON_FALL: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && !$stable(mosi)) |-> $fell(sclk)); // R2

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    (done && busy) |=> !done); // R7

  AST_DONE_CS_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    done |-> csN); // R7

  AST_EMPTY_DONE: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && chanMask == '0) |=> (done && !busy)); // R9

  AST_ERR_IN_SCAN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ioErr) |-> busy); // R8
endmodule

bind adc_scan_seq adc_scan_seq_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .chanMask(chanMask), .busy(busy),
  .done(done), .ioErr(ioErr), .sclk(sclk), .csN(csN), .mosi(mosi)
);

// File: tb/sim_adc_scan_seq.sv
module sim_adc_scan_seq;
  localparam int NCH  = 8;
  localparam int RES  = 10;
  localparam int HALF = 2;

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0, rangeRef = 1'b0, miso = 1'b0;
  logic [NCH-1:0] chanMask = '0;
  logic busy, done, ioErr, sclk, csN, mosi;
  logic [NCH-1:0] slotValid;
  logic [NCH*RES-1:0] bufData;

  adc_scan_seq #(.NUM_CH(NCH), .RES_BITS(RES), .SCLK_HALF(HALF)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .chanMask(chanMask), .rangeRef(rangeRef),
    .busy(busy), .done(done), .ioErr(ioErr), .slotValid(slotValid), .bufData(bufData),
    .sclk(sclk), .csN(csN), .mosi(mosi), .miso(miso)
  );

  always #5 clk = ~clk;

  int nChecks = 0, nFails = 0, cycle = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // behavioural converter model
  logic [15:0] shIn = '0, shOut = '0, nextResp = 16'hF0F0;
  int bitIn = 0, corruptChan = -1, scanId = 0;
  bit inFrame = 0;
  logic [15:0] cmdLog[$];

  function automatic logic [11:0] sampleOf(input int ch);
    return 12'((ch * 419 + scanId * 91 + 709) % 4096);
  endfunction

  always @(negedge csN) begin
    inFrame = 1; bitIn = 0; shOut = nextResp;
  end
  always @(negedge sclk) if (!csN) begin
    miso = shOut[15]; shOut = {shOut[14:0], 1'b0};
  end
  always @(posedge sclk) if (!csN) begin
    shIn = {shIn[14:0], mosi}; bitIn++;
  end
  always @(posedge csN) if (inFrame) begin
    int ch;
    inFrame = 0;
    chk(bitIn == 16, "R2", "sclk rises per frame", bitIn, 16);
    cmdLog.push_back(shIn);
    if (shIn[15]) begin
      ch = int'(shIn[12:10]);
      nextResp = {(ch == corruptChan) ? 4'(ch ^ 1) : 4'(ch), sampleOf(ch)};
    end else begin
      nextResp = 16'hF0F0;
    end
  end

  // per-cycle reference for completion timing and chip-select gaps
  logic prevCs = 1'b1;
  int framesSeen = 0, expFrames = 0, csHighRun = 100, csFalls = 0;
  bit emptyPending = 0, doneSeen = 0;

  always @(posedge clk) begin
    #2;
    cycle++;
    if (cycle == 150000) begin
      chk(0, "WD", "watchdog expired", cycle, 0);
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
    if (rstN) begin
      bit rose, fell, expD;
      rose = csN && !prevCs;
      fell = !csN && prevCs;
      if (rose) framesSeen++;
      if (fell) begin
        csFalls++;
        chk(csHighRun >= 2*HALF, "R11", "chip-select gap cycles", csHighRun, 2*HALF);
      end
      csHighRun = csN ? csHighRun + 1 : 0;
      expD = (rose && expFrames > 0 && framesSeen == expFrames) || emptyPending;
      if (done || expD) chk(done == expD, "R7", "done timing", int'(done), int'(expD));
      if (done) doneSeen = 1;
      emptyPending = 0;
      prevCs = csN;
    end
  end

  task automatic runScan(input logic [NCH-1:0] m, input bit rng, input int corrupt, input bit poke);
    int chans[$];
    logic [NCH*RES-1:0] oldBuf;
    int bad;
    for (int i = 0; i < NCH; i++) if (m[i]) chans.push_back(i);
    oldBuf = bufData;
    corruptChan = corrupt;
    scanId++;
    cmdLog.delete();
    framesSeen = 0;
    expFrames = chans.size() + 1;
    doneSeen = 0;
    @(negedge clk); chanMask = m; rangeRef = rng; start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (poke) begin
      repeat (40) @(negedge clk);
      start = 1'b1; chanMask = ~m; rangeRef = ~rng;
      @(negedge clk); start = 1'b0;
    end
    while (!doneSeen) @(negedge clk);
    while (busy) @(negedge clk);
    chk(cmdLog.size() == chans.size() + 1, (chans.size() == 1) ? "R12" : "R5",
        "frame count", cmdLog.size(), chans.size() + 1);
    bad = 0;
    for (int i = 0; i < chans.size() && i < cmdLog.size(); i++) begin
      int exp;
      exp = 32'h8000 | (chans[i] << 10) | 32'h0300 | (int'(rng) << 5) | 32'h0010;
      chk(int'(cmdLog[i]) == exp, "R1", "command word", int'(cmdLog[i]), exp);
      chk(cmdLog[i][5] == rng, "R3", "range bit", int'(cmdLog[i][5]), int'(rng));
      if (int'(cmdLog[i]) != exp) bad++;
    end
    if (poke) chk(bad == 0, "R10", "commands altered by start while busy", bad, 0);
    if (cmdLog.size() > 0)
      chk(cmdLog[cmdLog.size()-1] == 16'h0000, "R5", "tail command word",
          int'(cmdLog[cmdLog.size()-1]), 0);
    for (int i = 0; i < chans.size(); i++) begin
      int got, exp;
      got = int'(bufData[i*RES +: RES]);
      if (chans[i] == corrupt) begin
        exp = int'(oldBuf[i*RES +: RES]);
        chk(!slotValid[i], "R8", "mismatched slot valid", int'(slotValid[i]), 0);
        chk(got == exp, "R8", "mismatched slot data", got, exp);
      end else begin
        exp = int'(sampleOf(chans[i]) >> (12 - RES));
        chk(slotValid[i], "R6", "slot valid", int'(slotValid[i]), 1);
        chk(got == exp, "R4", "slot sample", got, exp);
      end
    end
    chk((slotValid >> chans.size()) == '0, "R6", "unused slots invalid", int'(slotValid), 0);
    bad = 0;
    foreach (chans[i]) if (chans[i] == corrupt) bad = 1;
    chk(int'(ioErr) == bad, "R8", "ioErr flag", int'(ioErr), bad);
    expFrames = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(csN == 1'b1, "R2", "reset csN", int'(csN), 1);
    chk(sclk == 1'b1, "R2", "reset sclk", int'(sclk), 1);
    chk(done == 1'b0 && busy == 1'b0, "R7", "reset done/busy", int'({done, busy}), 0);
    chk(slotValid == '0 && ioErr == 1'b0, "R6", "reset slots/err", int'(slotValid), 0);

    runScan(8'b0000_0100, 1'b0, -1, 1'b0);
    runScan(8'hFF, 1'b1, -1, 1'b1);
    runScan(8'b1010_0110, 1'b0, 5, 1'b0);
    runScan(8'b1001_0001, 1'b1, -1, 1'b0);

    begin
      int fallsBefore;
      fallsBefore = csFalls;
      doneSeen = 0;
      @(negedge clk); chanMask = '0; start = 1'b1; emptyPending = 1;
      @(negedge clk); start = 1'b0;
      chk(!busy, "R9", "busy after empty start", int'(busy), 0);
      repeat (20) @(negedge clk);
      chk(doneSeen, "R9", "done on empty mask", int'(doneSeen), 1);
      chk(csFalls == fallsBefore, "R9", "csN activity on empty mask", csFalls - fallsBefore, 0);
    end

    runScan(8'h80, 1'b1, -1, 1'b0);

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule